// File: doc/BRIEF.md
# Dual-Port Wake Event Aggregator

This block gathers interrupt causes from two Ethernet PHY ports and sends them along two paths. Each port keeps a vector of cause flags. The causes are energy-on, a wake-on-LAN hit, and general causes supplied by the PHY. A host-written mask selects which flags count as that port's interrupt.

The first path is a global interrupt status word. A port's interrupt shows up in this word one clock after the flag is set. Enabled status bits drive the `irq_o` pin.

The second path is a sticky wake status bit per port. Any masked port interrupt latches this bit, and it stays set until the host clears it. Enabled wake bits drive the `pme_o` level output, whose polarity the host can select.

The host reaches every register through a plain write strobe with an address and a combinational read bus. Cause flags and wake status bits are write-one-to-clear. The sticky bit of each port is a two-state machine:
- It has the states `WK_CLEAR` and `WK_LATCHED`.
- Transition *arm*: from `WK_CLEAR` to `WK_LATCHED` when the port interrupt is asserted.
- Transition *release*: from `WK_LATCHED` to `WK_CLEAR` on a host write-one with no interrupt present.
- Otherwise the machine holds its state.

Address map (word addresses):

| Addr | Register |
|------|----------|
| 0 | global status, read-only |
| 1 | interrupt enable |
| 2 | power control |
| 4 | port A flags |
| 5 | port A mask |
| 6 | port A control |
| 8 | port B flags |
| 9 | port B mask |
| 10 | port B control |

Top module: `wake_event_aggr`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and `pme_o` is 0.
- R2: A port flag bit sets on the clock after its cause is high and holds until the host writes a one to that bit at the port's flags address. A cause in the same cycle as that write keeps the bit set.
- R3: Flag bit 0 (energy-on) sets on every clock where the port's energy-detect power-down enable (control bit 0) is 1 and `energy_*_i` is high. If energy is already present when the enable is written, the flag sets on the next clock without any new edge. With the enable at 0, energy has no effect.
- R4: Flag bit 1 (wake-on-LAN) sets when any one of the four `wol_*_i` hit inputs is high. The four hits are destination-address match, broadcast, magic packet and wakeup frame.
- R5: A port interrupt is the OR over bits of flags AND mask. It appears one clock later in global status bit 26 for port A and bit 27 for port B. Clearing the flag drops the status bit one clock later. Writes to address 0 have no effect.
- R6: `irq_o` is the OR of global status bits 26 and 27, each ANDed with the same bit of the enable register at address 1.
- R7: Power control bit 0 (port A) and bit 1 (port B) latch on any masked port interrupt and stay set after the interrupt goes away. A write of one clears them only when no interrupt is present in that cycle.
- R8: `pme_o` equals the OR of (wake status bit 0 AND enable bit 4) and (wake status bit 1 AND enable bit 5), XORed with polarity bit 8 of power control.
- R9: Unused addresses and unimplemented bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_we | input | 1 | host write strobe |
| host_addr | input | 4 | host word address |
| host_wdata | input | 32 | host write data |
| host_rdata | output | 32 | read data for host_addr |
| cause_a_i | input | 8 | port A general cause levels |
| wol_a_i | input | 4 | port A wake-on-LAN hit levels |
| energy_a_i | input | 1 | port A energy present on cable |
| cause_b_i | input | 8 | port B general cause levels |
| wol_b_i | input | 4 | port B wake-on-LAN hit levels |
| energy_b_i | input | 1 | port B energy present on cable |
| irq_o | output | 1 | interrupt request pin |
| pme_o | output | 1 | wake event output, polarity programmable |

## Verification
The bench first raises a cause with the mask closed and then opens the mask. This separates flag capture from interrupt gating. A cause that coincides with its own write-one-clear shows which one takes priority.

Energy is applied before the energy-detect enable is set. This shows the flag is level-sensitive and not edge-triggered. Each of the four wake-on-LAN hits is pulsed on its own to show that all four reach flag bit 1.

Clearing the wake bit while its interrupt persists, and toggling the polarity bit, separate the sticky latch from the output stage.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int ED_BIT  = 0;
    localparam int WOL_BIT = 1;

    localparam int ADR_STAT = 0;
    localparam int ADR_IEN  = 1;
    localparam int ADR_PMC  = 2;

    localparam int PMC_STS0 = 0;
    localparam int PMC_EN0  = 4;
    localparam int PMC_POL  = 8;

    typedef enum logic {
        WK_CLEAR   = 1'b0,
        WK_LATCHED = 1'b1
    } wake_state_e;
endpackage

// File: rtl/phy_src_flags.sv
module phy_src_flags
    import wake_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int NWOL = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cause_i,
    input  logic [NWOL-1:0] wol_hit_i,
    input  logic            energy_i,
    input  logic            edpd_en_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] flags_o,
    output logic            irq_o
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] flags_q;

    always_comb begin
        set_vec          = cause_i;
        set_vec[ED_BIT]  = cause_i[ED_BIT] | (edpd_en_i & energy_i);
        set_vec[WOL_BIT] = cause_i[WOL_BIT] | (|wol_hit_i);
    end

    // Set has priority over write-one-clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_vec;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & mask_i);

    // R2: a cause seen at an edge is held in the flags afterwards.
    assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_q & $past(set_vec)) == $past(set_vec)));

    // R3: energy with the enable set always reaches the energy-on flag.
    assert_energy_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (edpd_en_i && energy_i) |=> flags_q[ED_BIT]);
endmodule

// File: rtl/wake_latch.sv
module wake_latch
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic clr_i,
    output logic sts_o
);
    wake_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_CLEAR:   if (irq_i)                state_d = WK_LATCHED;
            WK_LATCHED: if (clr_i && !irq_i)      state_d = WK_CLEAR;
            default:                              state_d = WK_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_CLEAR;
        else        state_q <= state_d;
    end

    always_comb sts_o = (state_q == WK_LATCHED);

    assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> state_q == WK_LATCHED);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WK_LATCHED && !clr_i) |=> state_q == WK_LATCHED);
endmodule

// File: rtl/wake_event_aggr.sv
module wake_event_aggr
    import wake_pkg::*;
#(
    parameter int NSRC      = 8,
    parameter int NWOL      = 4,
    parameter int DW        = 32,
    parameter int AW        = 4,
    parameter int IRQ_A_BIT = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    input  logic [NSRC-1:0] cause_a_i,
    input  logic [NWOL-1:0] wol_a_i,
    input  logic            energy_a_i,
    input  logic [NSRC-1:0] cause_b_i,
    input  logic [NWOL-1:0] wol_b_i,
    input  logic            energy_b_i,
    output logic            irq_o,
    output logic            pme_o
);
    localparam int NPORT = 2;
    localparam int STRIDE = 4;

    logic [NSRC-1:0] cause_v  [NPORT];
    logic [NWOL-1:0] wol_v    [NPORT];
    logic            energy_v [NPORT];
    logic [NSRC-1:0] flags_v  [NPORT];
    logic [NSRC-1:0] mask_q   [NPORT];
    logic            edpd_q   [NPORT];
    logic [NPORT-1:0] phy_irq, stat_q, ien_q, wen_q, wsts;
    logic            pol_q;

    assign cause_v[0] = cause_a_i;  assign cause_v[1] = cause_b_i;
    assign wol_v[0]   = wol_a_i;    assign wol_v[1]   = wol_b_i;
    assign energy_v[0] = energy_a_i; assign energy_v[1] = energy_b_i;

    logic pmc_wr, ien_wr;
    assign pmc_wr = host_we && (host_addr == AW'(ADR_PMC));
    assign ien_wr = host_we && (host_addr == AW'(ADR_IEN));

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int BASE = STRIDE * (p + 1);
        logic flg_wr, msk_wr, ctl_wr;
        logic [NSRC-1:0] clr;

        assign flg_wr = host_we && (host_addr == AW'(BASE));
        assign msk_wr = host_we && (host_addr == AW'(BASE + 1));
        assign ctl_wr = host_we && (host_addr == AW'(BASE + 2));
        assign clr    = flg_wr ? host_wdata[NSRC-1:0] : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[p] <= '0;
                edpd_q[p] <= 1'b0;
            end else begin
                if (msk_wr) mask_q[p] <= host_wdata[NSRC-1:0];
                if (ctl_wr) edpd_q[p] <= host_wdata[0];
            end
        end

        phy_src_flags #(.NSRC(NSRC), .NWOL(NWOL)) u_flags (
            .clk       (clk),
            .rst_n     (rst_n),
            .cause_i   (cause_v[p]),
            .wol_hit_i (wol_v[p]),
            .energy_i  (energy_v[p]),
            .edpd_en_i (edpd_q[p]),
            .clr_i     (clr),
            .mask_i    (mask_q[p]),
            .flags_o   (flags_v[p]),
            .irq_o     (phy_irq[p])
        );

        wake_latch u_wake (
            .clk   (clk),
            .rst_n (rst_n),
            .irq_i (phy_irq[p]),
            .clr_i (pmc_wr && host_wdata[PMC_STS0 + p]),
            .sts_o (wsts[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            ien_q  <= '0;
            wen_q  <= '0;
            pol_q  <= 1'b0;
        end else begin
            stat_q <= phy_irq;
            if (ien_wr) ien_q <= host_wdata[IRQ_A_BIT +: NPORT];
            if (pmc_wr) begin
                wen_q <= host_wdata[PMC_EN0 +: NPORT];
                pol_q <= host_wdata[PMC_POL];
            end
        end
    end

    assign irq_o = |(stat_q & ien_q);
    assign pme_o = (|(wsts & wen_q)) ^ pol_q;

    always_comb begin
        host_rdata = '0;
        if (host_addr == AW'(ADR_STAT)) begin
            host_rdata[IRQ_A_BIT +: NPORT] = stat_q;
        end else if (host_addr == AW'(ADR_IEN)) begin
            host_rdata[IRQ_A_BIT +: NPORT] = ien_q;
        end else if (host_addr == AW'(ADR_PMC)) begin
            host_rdata[PMC_STS0 +: NPORT] = wsts;
            host_rdata[PMC_EN0 +: NPORT]  = wen_q;
            host_rdata[PMC_POL]           = pol_q;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (host_addr == AW'(STRIDE * (p + 1)))     host_rdata[NSRC-1:0] = flags_v[p];
                if (host_addr == AW'(STRIDE * (p + 1) + 1)) host_rdata[NSRC-1:0] = mask_q[p];
                if (host_addr == AW'(STRIDE * (p + 1) + 2)) host_rdata[0]        = edpd_q[p];
            end
        end
    end

    // R5: a port interrupt reaches its global status bit one clock later.
    assert_stat_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_irq[0] |=> stat_q[0]);
    assert_stat_follows_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phy_irq[1] |=> stat_q[1]);

    // R8: the wake output leaves its idle level only with a latched port.
    assert_pme_needs_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_o != pol_q) |-> (|wsts));

    // R6: the request pin needs a set global status bit.
    assert_irq_needs_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|stat_q));
endmodule

// File: tb/test_wake_event_aggr.sv
module test_wake_event_aggr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  cause_a = '0, cause_b = '0;
    logic [3:0]  wol_a = '0, wol_b = '0;
    logic        energy_a = 1'b0, energy_b = 1'b0;
    logic        irq, pme;

    always #2 clk = ~clk;   // 250 MHz

    wake_event_aggr i_wake_event_aggr (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cause_a_i(cause_a), .wol_a_i(wol_a), .energy_a_i(energy_a),
        .cause_b_i(cause_b), .wol_b_i(wol_b), .energy_b_i(energy_b),
        .irq_o(irq), .pme_o(pme)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 irq pin, 2 pme pin
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    logic  chk_req = 1'b0;
    int    checks = 0, failures = 0;
    bit    done = 1'b0;

    // Monitor: pops one expected item per requested sample.
    always @(negedge clk) begin
        if (chk_req && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = (it.kind == 0) ? host_rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, pme};
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_item(int kind, logic [3:0] a, logic [31:0] e, string tag);
        item_t it;
        @(posedge clk); #1;
        host_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        chk_req = 1'b1;
        @(posedge clk); #1;
        chk_req = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic pulse_a(logic [7:0] c);
        @(posedge clk); #1; cause_a = c;
        @(posedge clk); #1; cause_a = '0;
    endtask

    task automatic pulse_wol_b(logic [3:0] w);
        @(posedge clk); #1; wol_b = w;
        @(posedge clk); #1; wol_b = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        expect_item(0, 4'd0, 32'h0, "R1 status after reset");
        expect_item(0, 4'd2, 32'h0, "R1 power control after reset");
        expect_item(1, 4'd0, 32'h0, "R1 irq after reset");
        expect_item(2, 4'd0, 32'h0, "R1 pme after reset");
        expect_item(0, 4'd3, 32'h0, "R9 unused address");

        pulse_a(8'h04);
        expect_item(0, 4'd4, 32'h4, "R2 flag captured");
        expect_item(0, 4'd0, 32'h0, "R5 mask closed keeps status low");
        wr(4'd0, 32'hFFFF_FFFF);
        expect_item(0, 4'd0, 32'h0, "R5 status write ignored");

        wr(4'd5, 32'h4);
        expect_item(0, 4'd0, 32'h0400_0000, "R5 port A at bit 26");
        expect_item(1, 4'd0, 32'h0, "R6 irq held by enable");
        expect_item(0, 4'd2, 32'h1, "R7 wake A latched");
        expect_item(2, 4'd0, 32'h0, "R8 pme held by enable");
        wr(4'd1, 32'h0400_0000);
        expect_item(1, 4'd0, 32'h1, "R6 irq enabled");

        // Cause and clear in the same cycle: cause wins.
        @(posedge clk); #1;
        cause_a = 8'h04; host_we = 1'b1; host_addr = 4'd4; host_wdata = 32'h4;
        @(posedge clk); #1;
        cause_a = '0; host_we = 1'b0;
        expect_item(0, 4'd4, 32'h4, "R2 cause wins over clear");

        wr(4'd4, 32'h4);
        expect_item(0, 4'd4, 32'h0, "R2 flag cleared");
        expect_item(0, 4'd0, 32'h0, "R5 status drops after clear");
        expect_item(1, 4'd0, 32'h0, "R6 irq drops");
        expect_item(0, 4'd2, 32'h1, "R7 wake A sticky");

        wr(4'd2, 32'h010);
        expect_item(2, 4'd0, 32'h1, "R8 pme active high");
        wr(4'd2, 32'h110);
        expect_item(2, 4'd0, 32'h0, "R8 pme active low");
        wr(4'd2, 32'h111);
        expect_item(0, 4'd2, 32'h110, "R7 wake A cleared");
        expect_item(2, 4'd0, 32'h1, "R8 pme idle high");

        energy_b = 1'b1;
        repeat (2) @(posedge clk);
        expect_item(0, 4'd8, 32'h0, "R3 energy ignored when disabled");
        wr(4'd10, 32'h1);
        expect_item(0, 4'd8, 32'h1, "R3 energy already present sets flag");
        energy_b = 1'b0;
        wr(4'd8, 32'h1);
        expect_item(0, 4'd8, 32'h0, "R3 energy flag cleared");

        for (int i = 0; i < 4; i++) begin
            pulse_wol_b(4'(1 << i));
            expect_item(0, 4'd8, 32'h2, $sformatf("R4 wake-on-LAN hit %0d", i));
            wr(4'd8, 32'h2);
        end

        wr(4'd9, 32'h2);
        pulse_wol_b(4'h4);
        expect_item(0, 4'd0, 32'h0800_0000, "R5 port B at bit 27");
        expect_item(0, 4'd2, 32'h112, "R7 wake B latched");
        expect_item(1, 4'd0, 32'h0, "R6 bit 27 not enabled");
        wr(4'd1, 32'h0C00_0000);
        expect_item(1, 4'd0, 32'h1, "R6 bit 27 enabled");
        wr(4'd2, 32'h112);
        expect_item(0, 4'd2, 32'h112, "R7 clear loses to live interrupt");
        wr(4'd2, 32'h120);
        expect_item(0, 4'd2, 32'h122, "R7 enables rewritten");
        expect_item(2, 4'd0, 32'h0, "R8 port B drives pme low");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule